// File: doc/BRIEF.md
# UART Modem Loopback Mapper

This block is the internal loopback path of a serial port. A control write carries a loopback-enable bit and four software-driven modem outputs (Out2, Out1, request-to-send, data-terminal-ready). While loopback is on, those outputs are cross-mapped onto the four modem status flags. The modem-status interrupt bits are rewritten to match, in the same write. Words written for transmission, and break requests, are turned back into the receive buffer's push port. Characters from the external receive input are dropped.

While loopback is off, the status flags follow the external modem pins. External receive characters go to the push port, and transmit words are accepted without being injected. The push port is valid/ready. A word offered on `push_valid` stays there, unchanged, until a cycle with `push_ready` high. The transmit and external-receive inputs are also valid/ready. A source whose word cannot be taken in a cycle sees its ready low. A transmit word offered while ready is low is not taken, and the sender must offer it again.

Top module: `lb_loopback_mapper`

## Requirements
- R1: After reset, `push_valid`, `ms_irq_wr`, `ms_irq_bits` and all four status flags are 0, and loopback is off.
- R2: On a control write with `ctl_loop_en`=1, the flags take these values in the next cycle: `st_ri`=Out2, `st_dcd`=Out1, `st_cts`=request-to-send, `st_dsr`=data-terminal-ready.
- R3: The mapping is applied on the very control write that turns loopback on, even when no other field changes.
- R4: Each control write with `ctl_loop_en`=1 raises `ms_irq_wr` for exactly one cycle. That cycle is the one in which the flags update. `ms_irq_bits` = {ri, dcd, cts, dsr} (bit 3 down to bit 0) of the new flags, so a bit that was set before but whose flag is now low reads 0.
- R5: While loopback is on, the flags hold between control writes, whatever the external modem pins do.
- R6: While loopback is off, each flag equals its external pin (`pin_ri`, `pin_dcd`, `pin_cts`, `pin_dsr`) as it was one cycle earlier, and `ms_irq_wr` stays 0.
- R7: While loopback is on, each accepted transmit word appears on the push port, zero-extended to the push width.
- R8: While loopback is on, a rising edge of `brk_req` queues exactly one break word. The break word has only bit 10 set (0x400). A pending break word is pushed before any transmit word.
- R9: While loopback is on, external receive characters are accepted (`erx_ready`=1) and discarded.
- R10: While loopback is off, external receive characters are pushed and transmit words are accepted without being pushed.
- R11: While `push_valid`=1 and `push_ready`=0, `push_data` holds its value. During that time `tx_ready` (in loopback) or `erx_ready` (otherwise) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_loop_en | input | 1 | Loopback enable field of the write |
| ctl_out2 | input | 1 | Out2 field |
| ctl_out1 | input | 1 | Out1 field |
| ctl_rts | input | 1 | Request-to-send field |
| ctl_dtr | input | 1 | Data-terminal-ready field |
| brk_req | input | 1 | Send-break level |
| pin_ri | input | 1 | External ring pin |
| pin_dcd | input | 1 | External carrier-detect pin |
| pin_cts | input | 1 | External clear-to-send pin |
| pin_dsr | input | 1 | External data-set-ready pin |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken |
| tx_data | input | DATA_W | Transmit word |
| erx_valid | input | 1 | External receive character offered |
| erx_ready | output | 1 | External receive character taken |
| erx_data | input | DATA_W | External receive character |
| push_valid | output | 1 | Receive push word valid |
| push_ready | input | 1 | Receive buffer can take the word |
| push_data | output | WORD_W | Receive push word |
| st_ri | output | 1 | Ring status flag |
| st_dcd | output | 1 | Carrier-detect status flag |
| st_cts | output | 1 | Clear-to-send status flag |
| st_dsr | output | 1 | Data-set-ready status flag |
| ms_irq_wr | output | 1 | Modem-status interrupt bits write strobe |
| ms_irq_bits | output | 4 | Modem-status interrupt bits {ri,dcd,cts,dsr} |

## Verification
The mapping is driven with each control output alone, with all of them together and with all of them cleared. The cleared case is sent as the bare enabling write, while the external pins are held at the opposite values. A swapped pair of flags, or a flag taken from the pins instead of the control write, therefore shows up as a mismatch. Transmit words, external characters and break edges are offered with `push_ready` both high and stalled, so that the following are each seen on the push port:
- lost words
- duplicated breaks
- wrong break-over-transmit order
- leaks of external data in loopback

Turning loopback off with new pin values then separates pin-following from held flags.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef struct packed {
    logic ri;
    logic dcd;
    logic cts;
    logic dsr;
  } mstat_t;

  localparam int BRK_POS = 10;
endpackage

// File: rtl/lb_modem_map.sv
module lb_modem_map
  import lb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ctl_wr,
  input  logic   ctl_loop_en,
  input  mstat_t ctl_map,
  input  mstat_t pins,
  output logic   loop_q,
  output mstat_t flags,
  output logic   ms_wr,
  output logic [3:0] ms_bits
);
  logic   map_now;
  logic   follow_pins;

  assign map_now     = ctl_wr && ctl_loop_en;
  assign follow_pins = ctl_wr ? !ctl_loop_en : !loop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q  <= 1'b0;
      flags   <= '0;
      ms_wr   <= 1'b0;
      ms_bits <= '0;
    end else begin
      ms_wr <= map_now;
      if (ctl_wr) loop_q <= ctl_loop_en;
      if (map_now) begin
        flags   <= ctl_map;
        ms_bits <= ctl_map;
      end else if (follow_pins) begin
        flags <= pins;
      end
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && !ctl_wr) |=> $stable(flags));
  p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_q && !ctl_wr) |=> (flags == $past(pins)));
  p_irq_loop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ms_wr |-> loop_q);
endmodule

// File: rtl/lb_brk_edge.sv
module lb_brk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_req,
  input  logic loop_on,
  output logic brk_rise
);
  logic brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else        brk_q <= brk_req;
  end

  assign brk_rise = brk_req && !brk_q && loop_on;

  p_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_rise |=> !brk_rise);
endmodule

// File: rtl/lb_push_arb.sv
module lb_push_arb
  import lb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_on,
  input  logic              brk_rise,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              erx_valid,
  output logic              erx_ready,
  input  logic [DATA_W-1:0] erx_data,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [WORD_W-1:0] push_data
);
  localparam logic [WORD_W-1:0] BRK_WORD = WORD_W'(1) << BRK_POS;

  logic brk_pend;
  logic slot_free;
  logic take_brk;

  assign slot_free = !push_valid || push_ready;
  assign take_brk  = slot_free && loop_on && brk_pend;
  assign tx_ready  = !loop_on || (slot_free && !brk_pend);
  assign erx_ready = loop_on || slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_valid <= 1'b0;
      push_data  <= '0;
      brk_pend   <= 1'b0;
    end else begin
      brk_pend <= (brk_pend && !take_brk) || brk_rise;
      if (slot_free) begin
        if (take_brk) begin
          push_valid <= 1'b1;
          push_data  <= BRK_WORD;
        end else if (loop_on && tx_valid) begin
          push_valid <= 1'b1;
          push_data  <= WORD_W'(tx_data);
        end else if (!loop_on && erx_valid) begin
          push_valid <= 1'b1;
          push_data  <= WORD_W'(erx_data);
        end else begin
          push_valid <= 1'b0;
        end
      end
    end
  end

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));
  p_brk_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_brk |=> (push_valid && push_data == BRK_WORD));
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && erx_valid && !tx_valid && !brk_pend && slot_free) |=> !push_valid);
endmodule

// File: rtl/lb_loopback_mapper.sv
module lb_loopback_mapper
  import lb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_loop_en,
  input  logic              ctl_out2,
  input  logic              ctl_out1,
  input  logic              ctl_rts,
  input  logic              ctl_dtr,
  input  logic              brk_req,
  input  logic              pin_ri,
  input  logic              pin_dcd,
  input  logic              pin_cts,
  input  logic              pin_dsr,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              erx_valid,
  output logic              erx_ready,
  input  logic [DATA_W-1:0] erx_data,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [WORD_W-1:0] push_data,
  output logic              st_ri,
  output logic              st_dcd,
  output logic              st_cts,
  output logic              st_dsr,
  output logic              ms_irq_wr,
  output logic [3:0]        ms_irq_bits
);
  mstat_t ctl_map, pins, flags;
  logic   loop_q, brk_rise;

  // Cross-mapping of control outputs onto status inputs
  assign ctl_map = '{ri: ctl_out2, dcd: ctl_out1, cts: ctl_rts, dsr: ctl_dtr};
  assign pins    = '{ri: pin_ri, dcd: pin_dcd, cts: pin_cts, dsr: pin_dsr};

  lb_modem_map i_map (
    .clk, .rst_n, .ctl_wr, .ctl_loop_en, .ctl_map, .pins,
    .loop_q, .flags, .ms_wr(ms_irq_wr), .ms_bits(ms_irq_bits)
  );

  lb_brk_edge i_brk (
    .clk, .rst_n, .brk_req, .loop_on(loop_q), .brk_rise
  );

  lb_push_arb #(.DATA_W(DATA_W), .WORD_W(WORD_W)) i_arb (
    .clk, .rst_n, .loop_on(loop_q), .brk_rise,
    .tx_valid, .tx_ready, .tx_data,
    .erx_valid, .erx_ready, .erx_data,
    .push_valid, .push_ready, .push_data
  );

  assign st_ri  = flags.ri;
  assign st_dcd = flags.dcd;
  assign st_cts = flags.cts;
  assign st_dsr = flags.dsr;
endmodule

// File: tb/test_lb_loopback_mapper.sv
`timescale 1ns/1ps
module test_lb_loopback_mapper;
  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, ctl_loop_en = 0, ctl_out2 = 0, ctl_out1 = 0, ctl_rts = 0, ctl_dtr = 0;
  logic brk_req = 0;
  logic [3:0] pins = 0;
  logic tx_valid = 0, erx_valid = 0, push_ready = 1;
  logic [7:0] tx_data = 0, erx_data = 0;
  logic tx_ready, erx_ready, push_valid, st_ri, st_dcd, st_cts, st_dsr, ms_irq_wr;
  logic [11:0] push_data;
  logic [3:0] ms_irq_bits;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lb_loopback_mapper i_lb_loopback_mapper (
    .clk, .rst_n, .ctl_wr, .ctl_loop_en, .ctl_out2, .ctl_out1, .ctl_rts, .ctl_dtr,
    .brk_req, .pin_ri(pins[3]), .pin_dcd(pins[2]), .pin_cts(pins[1]), .pin_dsr(pins[0]),
    .tx_valid, .tx_ready, .tx_data, .erx_valid, .erx_ready, .erx_data,
    .push_valid, .push_ready, .push_data, .st_ri, .st_dcd, .st_cts, .st_dsr,
    .ms_irq_wr, .ms_irq_bits
  );

  // Behavioural reference model
  bit m_loop, m_pv, m_pend, m_brk, m_wr;
  int m_pd, m_flags, m_bits;

  function automatic bit exp_tx_ready();
    return !m_loop || ((!m_pv || push_ready) && !m_pend);
  endfunction
  function automatic bit exp_erx_ready();
    return m_loop || !m_pv || push_ready;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_loop = 0; m_pv = 0; m_pend = 0; m_brk = 0; m_wr = 0;
      m_pd = 0; m_flags = 0; m_bits = 0;
    end else begin
      bit free, rise, took;
      free = !m_pv || push_ready;
      rise = brk_req && !m_brk && m_loop;
      took = 0;
      if (free) begin
        if (m_loop && m_pend) begin m_pv = 1; m_pd = 'h400; took = 1; end
        else if (m_loop && tx_valid) begin m_pv = 1; m_pd = tx_data; end
        else if (!m_loop && erx_valid) begin m_pv = 1; m_pd = erx_data; end
        else m_pv = 0;
      end
      m_pend = (m_pend && !took) || rise;
      m_brk = brk_req;
      m_wr = ctl_wr && ctl_loop_en;
      if (m_wr) begin
        m_flags = {ctl_out2, ctl_out1, ctl_rts, ctl_dtr};
        m_bits = m_flags;
      end else if (ctl_wr || !m_loop) m_flags = pins;
      if (ctl_wr) m_loop = ctl_loop_en;
    end
    #1;
    chk("R11 push_valid", push_valid, m_pv);
    if (m_pv) chk("R7 push_data", push_data, m_pd);
    chk("R2 flags", {st_ri, st_dcd, st_cts, st_dsr}, m_flags);
    chk("R4 ms_irq_wr", ms_irq_wr, m_wr);
    if (m_wr) chk("R4 ms_irq_bits", ms_irq_bits, m_bits);
    chk("R11 tx_ready", tx_ready, exp_tx_ready());
    chk("R9 erx_ready", erx_ready, exp_erx_ready());
  end

  task automatic ctl(bit lb, bit o2, bit o1, bit rts, bit dtr);
    @(negedge clk);
    ctl_wr = 1; ctl_loop_en = lb; ctl_out2 = o2; ctl_out1 = o1; ctl_rts = rts; ctl_dtr = dtr;
    @(negedge clk);
    ctl_wr = 0;
  endtask
  task automatic tx(logic [7:0] d);
    @(negedge clk); tx_valid = 1; tx_data = d;
    @(negedge clk); tx_valid = 0;
  endtask
  task automatic erx(logic [7:0] d);
    @(negedge clk); erx_valid = 1; erx_data = d;
    @(negedge clk); erx_valid = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1 push_valid", push_valid, 0);
    chk("R1 flags", {st_ri, st_dcd, st_cts, st_dsr}, 0);
    chk("R1 ms_irq_wr", ms_irq_wr, 0);
    // R6 flags follow pins with loopback off
    pins = 4'b1010; idle(2);
    chk("R6 pins follow", {st_ri, st_dcd, st_cts, st_dsr}, 4'b1010);
    // R10 external data forwarded, tx not injected
    erx(8'h5A);
    chk("R10 erx push", push_data, 12'h05A);
    tx(8'h77);
    chk("R10 tx not pushed", push_valid, 0);
    // R3 bare enabling write maps zeros despite pins high
    pins = 4'b1111;
    ctl(1, 0, 0, 0, 0);
    chk("R3 flags", {st_ri, st_dcd, st_cts, st_dsr}, 0);
    chk("R3 ms_irq_wr", ms_irq_wr, 1);
    chk("R3 ms_irq_bits", ms_irq_bits, 0);
    // R2 each control output alone
    ctl(1, 1, 0, 0, 0); chk("R2 ri<-out2", {st_ri, st_dcd, st_cts, st_dsr}, 4'b1000);
    ctl(1, 0, 1, 0, 0); chk("R2 dcd<-out1", {st_ri, st_dcd, st_cts, st_dsr}, 4'b0100);
    ctl(1, 0, 0, 1, 0); chk("R2 cts<-rts", {st_ri, st_dcd, st_cts, st_dsr}, 4'b0010);
    ctl(1, 0, 0, 0, 1); chk("R2 dsr<-dtr", {st_ri, st_dcd, st_cts, st_dsr}, 4'b0001);
    ctl(1, 1, 1, 1, 1); chk("R4 bits all", ms_irq_bits, 4'b1111);
    ctl(1, 0, 0, 1, 1); chk("R4 bits cleared", ms_irq_bits, 4'b0011);
    idle(1); chk("R4 one pulse", ms_irq_wr, 0);
    // R5 flags hold while pins move
    pins = 4'b0100; idle(3);
    chk("R5 hold", {st_ri, st_dcd, st_cts, st_dsr}, 4'b0011);
    // R7 transmit loopback
    tx(8'hA5);
    chk("R7 tx push", push_data, 12'h0A5);
    // R9 external data dropped in loopback
    erx(8'h3C); idle(1);
    chk("R9 dropped", push_valid, 0);
    // R8 break edge pushes one break word
    @(negedge clk); brk_req = 1;
    idle(2);
    chk("R8 break word", push_data, 12'h400);
    chk("R8 break valid", push_valid, 1);
    idle(3);
    chk("R8 single", push_valid, 0);
    // R8 break edge together with tx
    @(negedge clk); brk_req = 0;
    @(negedge clk); brk_req = 1; tx_valid = 1; tx_data = 8'h12;
    @(negedge clk); tx_valid = 0; tx_data = 8'h34; tx_valid = 1;
    @(negedge clk); tx_valid = 0; brk_req = 0;
    idle(3);
    // R11 back-pressure
    push_ready = 0;
    tx(8'h11);
    tx(8'h22);
    idle(2);
    chk("R11 stall data", push_data, 12'h011);
    chk("R11 stall ready", tx_ready, 0);
    push_ready = 1; idle(2);
    // R6 loopback off: pins followed again
    pins = 4'b1001;
    ctl(0, 1, 1, 1, 1);
    chk("R6 off follow", {st_ri, st_dcd, st_cts, st_dsr}, 4'b1001);
    chk("R6 no irq", ms_irq_wr, 0);
    push_ready = 0; erx(8'h66); erx(8'h67); idle(1);
    chk("R11 erx stall", erx_ready, 0);
    push_ready = 1; idle(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule